// File: doc/BRIEF.md
# Compare-Match Periodic Timer Channel

This block is one 16-bit timer channel. A free-running divide-by-64 prescaler turns the input clock into count ticks. On each tick the counter advances. When the counter equals the general (compare) register on a tick, the block sets a compare-match status flag. If the control register selects clear-on-match, the same tick also returns the counter to zero, so the channel produces one event every (general register + 1) ticks. The flag drives a level interrupt output through an enable bit.

Counting is gated by a single run input. The integrating chip drives it from this channel's bit of a start/stop register shared by several channels. Dropping the bit freezes the count. Raising it restarts the prescaler from zero, so the first tick arrives a full 64 input clocks later. Software reaches the registers over a simple byte-addressed bus with separate read and write strobes. To acknowledge the flag, software reads the status register and then writes a value with bit 0 cleared.

Top module: `cmpm_timer_ch`

## Requirements
- R1: Registers sit at these byte addresses: control 0, mode 1, I/O control 2, interrupt enable 4, status 5, counter 6, general register 8. The byte registers take `bus_wdata[7:0]` and read back zero-extended. The counter and general register take and return all 16 bits. Writes to other addresses are ignored, and reads from them return 0. The mode and I/O-control registers only hold their value.
- R2: After reset every register reads 0 and `irq_o` is low.
- R3: While `run_i` is 0 the counter keeps its value, apart from bus writes to it.
- R4: With control bits [2:0] = 3'b011, the counter advances once every 64 input clocks while `run_i` is 1. The first advance comes 64 clocks after `run_i` rises. With any other code in those bits the counter does not advance.
- R5: With control bits [7:5] = 3'b001, a tick that finds the counter equal to the general register loads 0 instead of incrementing. With any other code in those bits the counter increments and wraps from 0xFFFF to 0.
- R6: Status bit 0 (the match flag) is set by every tick that finds the counter equal to the general register, in either clear mode. Status bits [7:1] read 0.
- R7: A status write with bit 0 = 0 clears the flag only if status was read while the flag was set, and the flag has not been set again since. A write with bit 0 = 1 has no effect.
- R8: If the flag is set again between the acknowledging read and the zero-write, the flag stays set.
- R9: `irq_o` is high exactly while the flag is set and interrupt-enable bit 0 is 1.
- R10: A bus write to the counter in the same cycle as a tick wins: the counter takes the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | This channel's start/stop bit from the shared register |
| bus_addr | input | 4 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; arms the flag acknowledge when it reads status |
| bus_wdata | input | 16 | Write data; byte registers use bits [7:0] |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Level compare-match interrupt request |

## Verification
On every cycle the assertions check that:
- the count holds while stopped;
- no tick occurs while stopped, and no two ticks are back to back;
- a match in clear mode zeroes the counter;
- every match raises the flag;
- a bus load of the counter wins over a tick;
- a status write of 1 never drops the flag.

Other behaviours depend on history across many cycles, and only the bench scenarios show them:
- the exact 64-clock spacing and the phase restart on run;
- the full period of general register + 1 ticks;
- the read-then-write acknowledge, including a re-set that slips between the read and the write.

A cycle model in the bench follows random register traffic and run toggling, and every read and every cycle of the interrupt line is compared against it.

// File: rtl/cmpm_timer_pkg.sv
`timescale 1ns/1ps
package cmpm_timer_pkg;
  localparam int ADDR_W = 4;
  localparam int REG_W  = 8;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] OFS_MODE = 4'd1;
  localparam logic [ADDR_W-1:0] OFS_IOC  = 4'd2;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 4'd4;
  localparam logic [ADDR_W-1:0] OFS_STAT = 4'd5;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 4'd6;
  localparam logic [ADDR_W-1:0] OFS_GR   = 4'd8;

  // control register field codes
  localparam logic [2:0] PSC_DIV64 = 3'b011;
  localparam logic [2:0] CLR_ON_GR = 3'b001;

  localparam int NBYTE = 4;
  localparam logic [ADDR_W-1:0] BYTE_OFS [NBYTE] = '{OFS_CTRL, OFS_MODE, OFS_IOC, OFS_IEN};
endpackage

// File: rtl/cmpm_prescaler.sv
`timescale 1ns/1ps
module cmpm_prescaler #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q, pre_d;

  // held at zero while stopped, so a restart always begins a fresh period
  always_comb begin
    pre_d = pre_q;
    if (!run_i)
      pre_d = '0;
    else if (pre_q == LAST)
      pre_d = '0;
    else
      pre_d = pre_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick_o = run_i && (pre_q == LAST);
endmodule

// File: rtl/cmpm_counter.sv
`timescale 1ns/1ps
module cmpm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic             clr_en_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             hit;

  assign hit = adv_i && (cnt_q == cmp_i);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = load_val_i;
    else if (adv_i)
      cnt_d = (hit && clr_en_i) ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o   = cnt_q;
  assign match_o = hit;
endmodule

// File: rtl/cmpm_flag.sv
`timescale 1ns/1ps
module cmpm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_i,
  input  logic clr_req_i,
  output logic flag_o
);
  logic flag_q, flag_d;
  logic arm_q, arm_d;
  logic clr;

  assign clr = clr_req_i && arm_q;

  // a new set both wins over a clear and disarms the pending acknowledge
  always_comb begin
    flag_d = flag_q;
    arm_d  = arm_q;
    if (set_i) begin
      flag_d = 1'b1;
      arm_d  = 1'b0;
    end else if (clr) begin
      flag_d = 1'b0;
      arm_d  = 1'b0;
    end else if (rd_i && flag_q) begin
      arm_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/cmpm_timer_ch.sv
`timescale 1ns/1ps
module cmpm_timer_ch
  import cmpm_timer_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int PRE_DIV = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              irq_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // plain byte registers: control, mode, I/O control, interrupt enable
  logic [REG_W-1:0] byte_q [NBYTE];
  logic [REG_W-1:0] byte_d [NBYTE];

  for (genvar g = 0; g < NBYTE; g++) begin : g_byte
    always_comb begin
      byte_d[g] = byte_q[g];
      if (bus_wr && (bus_addr == BYTE_OFS[g]))
        byte_d[g] = bus_wdata[REG_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) byte_q[g] <= '0;
      else             byte_q[g] <= byte_d[g];
    end
  end

  logic [REG_W-1:0] ctrl_q, ien_q;
  assign ctrl_q = byte_q[0];
  assign ien_q  = byte_q[3];

  // general (compare) register
  logic [CNT_W-1:0] gr_q, gr_d;

  always_comb begin
    gr_d = gr_q;
    if (bus_wr && (bus_addr == OFS_GR))
      gr_d = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) gr_q <= '0;
    else             gr_q <= gr_d;
  end

  // tick generation and count enables
  logic tick, adv, clr_en, wr_cnt, match;
  logic [CNT_W-1:0] cnt;

  cmpm_prescaler #(.DIV(PRE_DIV)) u_pre (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .run_i  (run_i),
    .tick_o (tick)
  );

  assign adv    = tick && (ctrl_q[2:0] == PSC_DIV64);
  assign clr_en = (ctrl_q[7:5] == CLR_ON_GR);
  assign wr_cnt = bus_wr && (bus_addr == OFS_CNT);

  cmpm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .adv_i      (adv),
    .clr_en_i   (clr_en),
    .load_i     (wr_cnt),
    .load_val_i (bus_wdata),
    .cmp_i      (gr_q),
    .cnt_o      (cnt),
    .match_o    (match)
  );

  // compare-match flag with the read-then-write-zero acknowledge
  logic flag, rd_stat, wr_stat, clr_req;

  assign rd_stat = bus_rd && (bus_addr == OFS_STAT);
  assign wr_stat = bus_wr && (bus_addr == OFS_STAT);
  assign clr_req = wr_stat && !bus_wdata[0];

  cmpm_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .set_i     (match),
    .rd_i      (rd_stat),
    .clr_req_i (clr_req),
    .flag_o    (flag)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL: bus_rdata = CNT_W'(byte_q[0]);
      OFS_MODE: bus_rdata = CNT_W'(byte_q[1]);
      OFS_IOC:  bus_rdata = CNT_W'(byte_q[2]);
      OFS_IEN:  bus_rdata = CNT_W'(byte_q[3]);
      OFS_STAT: bus_rdata = CNT_W'(flag);
      OFS_CNT:  bus_rdata = cnt;
      OFS_GR:   bus_rdata = gr_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign irq_o = flag && ien_q[0];
endmodule

// File: rtl/cmpm_timer_chk.sv
`timescale 1ns/1ps
module cmpm_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             tick,
  input logic             adv,
  input logic             clr_en,
  input logic             wr_cnt,
  input logic             wr_stat,
  input logic             wbit0,
  input logic             flag,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp,
  input logic [CNT_W-1:0] wdata
);
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt) |=> $stable(cnt));                                 // R3

  AST_NO_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick);                                                     // R4

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);                                                     // R4

  AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && clr_en && (cnt == cmp) && !wr_cnt) |=> (cnt == '0));          // R5

  AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && (cnt == cmp)) |=> flag);                                     // R6

  AST_WRITE_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && wbit0 && flag) |=> flag);                                // R7

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt == $past(wdata)));                                   // R10
endmodule

bind cmpm_timer_ch cmpm_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .run     (run_i),
  .tick    (tick),
  .adv     (adv),
  .clr_en  (clr_en),
  .wr_cnt  (wr_cnt),
  .wr_stat (wr_stat),
  .wbit0   (bus_wdata[0]),
  .flag    (flag),
  .cnt     (cnt),
  .cmp     (gr_q),
  .wdata   (bus_wdata)
);

// File: tb/tb_cmpm_timer_ch.sv
`timescale 1ns/1ps
module tb_cmpm_timer_ch;
  logic        clk;
  logic        rst_n;
  logic        run_i;
  logic [3:0]  bus_addr;
  logic        bus_wr;
  logic        bus_rd;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  bit mon_on = 0;

  cmpm_timer_ch dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run_i),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // ---------------- reference model, built from the requirements ----------------
  logic [7:0]  m_ctrl, m_mode, m_ioc, m_ien;
  logic [15:0] m_cnt, m_gr;
  logic        m_flag, m_arm;
  int          m_pre;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 0; m_mode = 0; m_ioc = 0; m_ien = 0;
      m_cnt = 0; m_gr = 0; m_flag = 0; m_arm = 0; m_pre = 0;
    end else begin
      bit tk, ad, hit, clr;
      tk  = run_i && (m_pre == 63);
      ad  = tk && (m_ctrl[2:0] == 3'b011);
      hit = ad && (m_cnt == m_gr);
      clr = bus_wr && (bus_addr == 4'd5) && !bus_wdata[0] && m_arm;
      if (!run_i) m_pre = 0; else m_pre = (m_pre == 63) ? 0 : m_pre + 1;
      if (bus_wr && bus_addr == 4'd6) m_cnt = bus_wdata;
      else if (ad) m_cnt = (hit && m_ctrl[7:5] == 3'b001) ? 16'h0 : m_cnt + 16'h1;
      if (hit) begin m_flag = 1; m_arm = 0; end
      else if (clr) begin m_flag = 0; m_arm = 0; end
      else if (bus_rd && bus_addr == 4'd5 && m_flag) m_arm = 1;
      if (bus_wr) begin
        case (bus_addr)
          4'd0: m_ctrl = bus_wdata[7:0];
          4'd1: m_mode = bus_wdata[7:0];
          4'd2: m_ioc  = bus_wdata[7:0];
          4'd4: m_ien  = bus_wdata[7:0];
          4'd8: m_gr   = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [15:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return {8'h0, m_ctrl};
      4'd1: return {8'h0, m_mode};
      4'd2: return {8'h0, m_ioc};
      4'd4: return {8'h0, m_ien};
      4'd5: return {15'h0, m_flag};
      4'd6: return m_cnt;
      4'd8: return m_gr;
      default: return 16'h0;
    endcase
  endfunction

  // ---------------- checking helpers ----------------
  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // look at a register without a bus cycle (combinational read path)
  task automatic peek(input logic [3:0] a, input logic [15:0] exp, input string req);
    bus_addr = a;
    #1;
    chk(bus_rdata, exp, req);
  endtask

  // all bus tasks start and end at a falling edge
  task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, input string req);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    chk(bus_rdata, m_read(a), req);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  always @(negedge clk) begin
    if (mon_on && !done) begin
      total++;
      if (irq_o !== (m_flag & m_ien[0])) begin
        bad++;
        $display("FAIL R9 irq act=%b exp=%b t=%0t", irq_o, m_flag & m_ien[0], $time);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [15:0] held;
    void'($urandom(32'h1D5E));
    rst_n = 1'b0; run_i = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    mon_on = 1;

    // R2: reset state
    peek(4'd0, 16'h0, "R2 ctrl"); peek(4'd1, 16'h0, "R2 mode");
    peek(4'd2, 16'h0, "R2 ioc");  peek(4'd4, 16'h0, "R2 ien");
    peek(4'd5, 16'h0, "R2 stat"); peek(4'd6, 16'h0, "R2 cnt");
    peek(4'd8, 16'h0, "R2 gr");   chk({15'h0, irq_o}, 16'h0, "R2 irq");

    // R1: map, widths, unmapped addresses
    bus_write(4'd1, 16'hC35A); peek(4'd1, 16'h005A, "R1 mode byte");
    bus_write(4'd2, 16'h77A5); peek(4'd2, 16'h00A5, "R1 ioc byte");
    bus_write(4'd8, 16'hBEEF); peek(4'd8, 16'hBEEF, "R1 gr word");
    bus_write(4'd6, 16'h8001); peek(4'd6, 16'h8001, "R1 cnt word");
    bus_write(4'd3, 16'hFFFF); peek(4'd3, 16'h0000, "R1 unmapped");
    peek(4'd4, 16'h0000, "R1 ien untouched");
    bus_write(4'd0, 16'h0023); bus_read(4'd0, "R1 ctrl");
    bus_write(4'd6, 16'h0000); bus_write(4'd8, 16'h0002);

    // R4: first tick exactly 64 clocks after start
    run_i = 1'b1;
    repeat (63) @(negedge clk); peek(4'd6, 16'h0000, "R4 before first tick");
    @(negedge clk);             peek(4'd6, 16'h0001, "R4 first tick");
    // R5/R6: period of gr+1 ticks
    repeat (64) @(negedge clk); peek(4'd6, 16'h0002, "R5 at compare value");
    peek(4'd5, 16'h0000, "R6 no early flag");
    repeat (64) @(negedge clk); peek(4'd6, 16'h0000, "R5 cleared on match");
    peek(4'd5, 16'h0001, "R6 flag on match");

    // R3: halt holds the count
    run_i = 1'b0;
    repeat (200) @(negedge clk); peek(4'd6, 16'h0000, "R3 held while stopped");

    // R7/R9: acknowledge rules and interrupt gating
    chk({15'h0, irq_o}, 16'h0, "R9 masked");
    bus_write(4'd4, 16'h0001); chk({15'h0, irq_o}, 16'h1, "R9 enabled");
    bus_write(4'd5, 16'h00FE); peek(4'd5, 16'h0001, "R7 zero-write without read");
    bus_read(4'd5, "R7 read arms");
    bus_write(4'd5, 16'h00FF); peek(4'd5, 16'h0001, "R7 write one no effect");
    bus_write(4'd5, 16'h00FE); peek(4'd5, 16'h0000, "R7 acknowledged");
    chk({15'h0, irq_o}, 16'h0, "R9 drops with flag");
    bus_write(4'd5, 16'h0001); peek(4'd5, 16'h0000, "R7 write one no set");

    // R8: re-set between read and zero-write
    bus_write(4'd8, 16'h0000); bus_write(4'd6, 16'h0000);
    run_i = 1'b1;
    repeat (64) @(negedge clk); peek(4'd5, 16'h0001, "R6 match every tick");
    bus_read(4'd5, "R8 read");
    repeat (64) @(negedge clk);
    bus_write(4'd5, 16'h00FE); peek(4'd5, 16'h0001, "R8 flag survives");
    bus_read(4'd5, "R8 second read");
    bus_write(4'd5, 16'h00FE); peek(4'd5, 16'h0000, "R7 clean acknowledge");
    run_i = 1'b0;
    @(negedge clk);

    // R10: load in the tick cycle
    bus_write(4'd8, 16'h0100); bus_write(4'd6, 16'h0000);
    run_i = 1'b1;
    repeat (63) @(negedge clk);
    bus_write(4'd6, 16'h1234); peek(4'd6, 16'h1234, "R10 load beats tick");
    repeat (63) @(negedge clk); peek(4'd6, 16'h1234, "R4 spacing after load");
    @(negedge clk);             peek(4'd6, 16'h1235, "R4 next tick");
    run_i = 1'b0;
    @(negedge clk);

    // R5: free-running mode keeps counting past the compare value, flag still set
    bus_write(4'd0, 16'h0003); bus_write(4'd6, 16'h0003); bus_write(4'd8, 16'h0003);
    run_i = 1'b1;
    repeat (64) @(negedge clk);
    peek(4'd6, 16'h0004, "R5 no clear in free-run");
    peek(4'd5, 16'h0001, "R6 flag in free-run");
    run_i = 1'b0;
    bus_write(4'd6, 16'hFFFF); bus_write(4'd8, 16'h1000);
    run_i = 1'b1;
    repeat (64) @(negedge clk); peek(4'd6, 16'h0000, "R5 wrap");
    run_i = 1'b0;

    // R4: another prescale code does not count
    bus_write(4'd0, 16'h0022); held = 16'h0000;
    run_i = 1'b1;
    repeat (200) @(negedge clk); peek(4'd6, held, "R4 other prescale code");
    run_i = 1'b0;
    @(negedge clk);

    // random traffic against the model
    for (int i = 0; i < 2500; i++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0: bus_write(4'd0, ($urandom_range(0, 4) != 0) ? 16'h0023 : 16'($urandom_range(0, 255)));
        1: bus_write(($urandom_range(0, 1) != 0) ? 4'd1 : 4'd2, 16'($urandom));
        2: bus_write(4'd8, ($urandom_range(0, 3) != 0) ? 16'($urandom_range(0, 7)) : 16'($urandom));
        3: bus_write(4'd6, 16'($urandom_range(0, 7)));
        4: bus_write(4'd4, 16'($urandom_range(0, 3)));
        5: begin
             bus_read(4'd5, "R7 random status");
             if ($urandom_range(0, 9) < 7) bus_write(4'd5, 16'h00FE);
             else bus_write(4'd5, 16'($urandom_range(0, 255)));
             bus_read(4'd5, "R8 random status after write");
           end
        6: bus_read(4'($urandom_range(0, 9)), "R1 random read");
        7: begin run_i = ~run_i; @(negedge clk); end
        default: repeat ($urandom_range(1, 120)) @(negedge clk);
      endcase
    end
    run_i = 1'b0;
    bus_read(4'd6, "R3 final count");
    bus_read(4'd5, "R6 final status");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule